// File: doc/BRIEF.md
# Software Interrupt Target Dispatcher

This block takes a 64-bit software-interrupt request word from one core and works out which cores receive the interrupt. It walks a per-core affinity table, one core per clock cycle. For every core it selects, it emits a one-cycle pulse that carries the core index and the interrupt number. The downstream pending logic sets the latch for that interrupt on that core.

There are two routing modes.
- In targeted mode, a core is chosen when its three upper affinity levels equal the requested ones and its level-0 value selects a bit set in the 16-bit target list. Each chosen core clears its bit from a working copy of the list, and the walk ends as soon as that copy is empty.
- In broadcast mode, every core except the requester is chosen.

A `done` pulse marks the end of every walk, whether the walk covers all cores or stops early.

Top module: `sgi_target_walker`

## Requirements
- R1: After reset, `busy`, `sig_valid` and `done` are low and stay low until a start is accepted.
- R2: Request word fields: target list [15:0], level-1 affinity [23:16], interrupt ID [27:24], level-2 affinity [39:32], routing-mode bit 40 (1 = broadcast), level-3 affinity [55:48]. Affinity table entry i sits at bits [32*i+31:32*i] and holds level 3 [31:24], level 2 [23:16], level 1 [15:8] and level 0 [7:0].
- R3: In broadcast mode, every core except `req_core` gets exactly one pulse. The walk covers all NCORES cores.
- R4: In targeted mode, a core is chosen only when levels 3, 2 and 1 all match and bit level-0 of the working list is set. A level-0 value of 16 or more never matches.
- R5: A chosen core clears its level-0 bit from the working list. A later core with the same affinity is therefore not chosen.
- R6: In targeted mode, the walk ends in the cycle the working list becomes zero. `done` coincides with the pulse for the last match. An empty list at start ends the walk after one cycle with no pulse.
- R7: Otherwise the walk ends after core NCORES-1 is checked. `done` is a one-cycle pulse in the cycle that follows the last check, and `busy` falls on the same edge.
- R8: The pulse for core k appears k+1 cycles after the accepting edge. Pulses come at most one per cycle, in ascending core order, with `sig_intid` equal to the request's interrupt ID.
- R9: A start that arrives while `busy` is high is ignored. The walk in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| req_word | input | 64 | Software-interrupt request word |
| req_core | input | IDXW | Index of the requesting core |
| aff_table | input | 32*NCORES | Affinity value of each core |
| busy | output | 1 | Walk in progress |
| sig_valid | output | 1 | Pending-set pulse |
| sig_core | output | IDXW | Core that receives the interrupt |
| sig_intid | output | 4 | Interrupt ID to set pending |
| done | output | 1 | Walk finished |

## Verification
The hardest case to reach is a walk that stops early because of a cleared bit. The list must empty exactly on a match, while a later core with a duplicate affinity would otherwise be chosen again. The bench table gives two cores the same affinity and places a core with an out-of-range level-0 value near the end. It then issues lists that empty on the first duplicate, that never empty, or that are empty from the start. A second start is injected mid-walk to show that it is dropped.

// File: rtl/sgi_target_walker.sv
module sgi_target_walker #(
  parameter int NCORES = 8,
  parameter int IDXW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [63:0]          req_word,
  input  logic [IDXW-1:0]      req_core,
  input  logic [32*NCORES-1:0] aff_table,
  output logic                 busy,
  output logic                 sig_valid,
  output logic [IDXW-1:0]      sig_core,
  output logic [3:0]           sig_intid,
  output logic                 done
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NCORES - 1);

  logic [IDXW-1:0] idx_q, req_q;
  logic [15:0]     mask_q, mask_nx;
  logic [7:0]      a1_q, a2_q, a3_q;
  logic [3:0]      id_q;
  logic            bc_q;
  logic [31:0]     entry;
  logic            in_list, aff_ok, hit, last;

  always_comb begin
    entry = '0;
    for (int i = 0; i < NCORES; i++)
      if (idx_q == IDXW'(i)) entry = aff_table[32*i +: 32];
  end

  assign aff_ok  = entry[31:24] == a3_q && entry[23:16] == a2_q && entry[15:8] == a1_q;
  assign in_list = entry[7:4] == 4'd0 && mask_q[entry[3:0]];
  assign hit     = bc_q ? (idx_q != req_q) : (aff_ok && in_list);
  assign mask_nx = (hit && !bc_q) ? (mask_q & ~(16'd1 << entry[3:0])) : mask_q;
  assign last    = (idx_q == LAST_IDX) || (!bc_q && mask_nx == 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; idx_q <= '0; req_q <= '0; mask_q <= '0;
      a1_q <= '0; a2_q <= '0; a3_q <= '0; id_q <= '0; bc_q <= 1'b0;
      sig_valid <= 1'b0; sig_core <= '0; sig_intid <= '0; done <= 1'b0;
    end else begin
      sig_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          idx_q  <= '0;
          req_q  <= req_core;
          mask_q <= req_word[15:0];
          a1_q   <= req_word[23:16];
          id_q   <= req_word[27:24];
          a2_q   <= req_word[39:32];
          bc_q   <= req_word[40];
          a3_q   <= req_word[55:48];
        end
      end else begin
        sig_valid <= hit;
        sig_core  <= idx_q;
        sig_intid <= id_q;
        mask_q    <= mask_nx;
        idx_q     <= idx_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sgi_walker_chk.sv
module sgi_walker_chk #(
  parameter int NCORES = 8,
  parameter int IDXW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [63:0]     req_word,
  input logic [IDXW-1:0] req_core,
  input logic            busy,
  input logic            sig_valid,
  input logic [IDXW-1:0] sig_core,
  input logic [3:0]      sig_intid,
  input logic            done
);
  logic [IDXW-1:0] lat_req, last_core;
  logic [3:0]      lat_id;
  logic            lat_bc, seen;
  logic [7:0]      cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_req <= '0; last_core <= '0; lat_id <= '0; lat_bc <= 1'b0; seen <= 1'b0; cnt <= '0;
    end else begin
      if (start && !busy) begin
        lat_req <= req_core; lat_id <= req_word[27:24]; lat_bc <= req_word[40];
        seen <= 1'b0; cnt <= '0;
      end else begin
        if (busy) cnt <= cnt + 8'd1;
        if (sig_valid) begin seen <= 1'b1; last_core <= sig_core; end
      end
    end
  end

  p_intid_r8: assert property (@(posedge clk) disable iff (!rst_n) sig_valid |-> sig_intid == lat_id);
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n) (sig_valid && seen) |-> sig_core > last_core);
  p_skip_self_r3: assert property (@(posedge clk) disable iff (!rst_n) (sig_valid && lat_bc) |-> sig_core != lat_req);
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));
  p_pulse_in_walk_r1: assert property (@(posedge clk) disable iff (!rst_n) sig_valid |-> $past(busy));
  p_walk_len_r7: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cnt < 8'(NCORES));
endmodule

bind sgi_target_walker sgi_walker_chk #(.NCORES(NCORES), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_word(req_word), .req_core(req_core),
  .busy(busy), .sig_valid(sig_valid), .sig_core(sig_core), .sig_intid(sig_intid), .done(done));

// File: tb/tb_sgi_target_walker.sv
module tb_sgi_target_walker;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [63:0] req_word = '0;
  logic [IW-1:0] req_core = '0;
  logic [32*N-1:0] aff_table;
  logic busy, sig_valid, done;
  logic [IW-1:0] sig_core;
  logic [3:0] sig_intid;

  int checks = 0, failures = 0;
  int q_busy[$], q_valid[$], q_core[$], q_id[$], q_done[$];
  int exp_busy = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  sgi_target_walker #(.NCORES(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_word(req_word), .req_core(req_core),
    .aff_table(aff_table), .busy(busy), .sig_valid(sig_valid), .sig_core(sig_core),
    .sig_intid(sig_intid), .done(done));

  function automatic logic [31:0] aff(int a3, int a2, int a1, int a0);
    return {8'(a3), 8'(a2), 8'(a1), 8'(a0)};
  endfunction

  function automatic logic [63:0] mkword(int a3, int a2, int a1, int id, bit bc, int list);
    logic [63:0] w = '0;
    w[15:0] = 16'(list); w[23:16] = 8'(a1); w[27:24] = 4'(id);
    w[39:32] = 8'(a2); w[40] = bc; w[55:48] = 8'(a3);
    return w;
  endfunction

  task automatic push(int b, int v, int c, int id, int d);
    q_busy.push_back(b); q_valid.push_back(v); q_core.push_back(c);
    q_id.push_back(id); q_done.push_back(d);
  endtask

  task automatic model(logic [63:0] w, int rq);
    int mask = w[15:0];
    bit bc = w[40];
    push(1, 0, 0, 0, 0);
    for (int c = 0; c < N; c++) begin
      logic [31:0] e = aff_table[32*c +: 32];
      bit hit, last;
      if (bc) hit = (c != rq);
      else hit = e[31:24] == w[55:48] && e[23:16] == w[39:32] && e[15:8] == w[23:16]
                 && e[7:0] < 16 && mask[e[3:0]];
      if (hit && !bc) mask = mask & ~(1 << e[3:0]);
      last = (c == N-1) || (!bc && mask == 0);
      push(last ? 0 : 1, hit, c, w[27:24], last);
      if (last) break;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: %s actual=%0d expected=%0d", cur_req, tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (q_busy.size() == 0) begin
      chk("busy idle", busy, 0); chk("valid idle", sig_valid, 0); chk("done idle", done, 0);
      exp_busy = 0;
    end else begin
      int b = q_busy.pop_front(), v = q_valid.pop_front(), c = q_core.pop_front();
      int id = q_id.pop_front(), d = q_done.pop_front();
      chk("busy", busy, b); chk("valid", sig_valid, v); chk("done", done, d);
      if (v) begin chk("core", sig_core, c); chk("intid", sig_intid, id); end
      exp_busy = b;
    end
  endtask

  task automatic issue(logic [63:0] w, int rq);
    start = 1; req_word = w; req_core = IW'(rq);
    if (!exp_busy) model(w, rq);
    tick();
    start = 0;
  endtask

  task automatic drain();
    while (q_busy.size() > 0) tick();
    tick();
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) aff_table[32*i +: 32] = aff(0, 0, i / 4, i % 4);
    aff_table[32*6 +: 32] = aff(0, 0, 0, 1);
    aff_table[32*7 +: 32] = aff(0, 0, 1, 20);
    cur_req = "R1";
    tick(); tick();
    rst_n = 1;
    tick(); tick();
    cur_req = "R3"; issue(mkword(0, 0, 0, 5, 1, 0), 3); drain();
    cur_req = "R6"; issue(mkword(0, 0, 0, 9, 0, 16'h0003), 0); drain();
    cur_req = "R8"; issue(mkword(0, 0, 0, 2, 0, 16'h000A), 0); drain();
    cur_req = "R5"; issue(mkword(0, 0, 0, 7, 0, 16'h0022), 0); drain();
    cur_req = "R4"; issue(mkword(0, 0, 1, 12, 0, 16'hFFFF), 0); drain();
    cur_req = "R2"; issue(mkword(0, 1, 0, 3, 0, 16'hFFFF), 0); drain();
    cur_req = "R2"; issue(mkword(2, 0, 0, 3, 0, 16'hFFFF), 0); drain();
    cur_req = "R6"; issue(mkword(0, 0, 0, 4, 0, 0), 0); drain();
    cur_req = "R7"; issue(mkword(0, 0, 0, 15, 1, 0), 7); drain();
    cur_req = "R9"; issue(mkword(0, 0, 0, 6, 1, 0), 0);
    tick();
    issue(mkword(0, 0, 0, 1, 0, 16'h0001), 2);
    issue(mkword(0, 0, 1, 11, 1, 0), 5);
    drain();
    cur_req = "R3"; issue(mkword(0, 0, 0, 8, 1, 16'hFFFF), 0); drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule